// File: doc/BRIEF.md
# Speculative Virtual-Channel and Switch Allocator

This block is the allocation stage of a virtual-channel router. Each input port holds several input virtual channels (input VCs), and the flit at the front of each one is presented with its kind (head, tail, or both) and, for a head flit, the output port it was routed to. The block decides, every cycle, which input VC is given an output virtual channel (output VC) and which flits cross the crossbar. Route computation, flit buffers and the crossbar datapath are outside the block.

A head flit asks for an output VC and a crossbar slot in the same cycle. Its switch request is speculative: it is made on the assumption that the VC request will succeed. If the VC request fails, the switch grant is thrown away and both requests are made again next cycle. Body and tail flits use the output VC their packet already holds and ask only for the switch. These non-speculative requests always beat speculative ones for the same output. Both allocation stages are separable and use round-robin arbiters. The block also keeps track of which output VCs are held by packets.

Each input VC runs a four-state machine. A head flit first moves it from idle to routing, which is one cycle to capture the route. After that it allocates. If allocation fails it goes to waiting-for-VC. Once it holds a VC it is active, and it returns to idle when its tail flit crosses the switch.

Top module: `spec_vc_sw_alloc`

## Requirements
- R1: After reset every input VC is idle (state code 0), and no VC grant, switch grant or crossbar output is asserted.
- R2: An idle input VC that sees a valid head flit grants nothing in that cycle. It moves to routing (code 1) on the next edge and captures the output port given with the flit.
- R3: In routing or waiting-for-VC (code 2), a valid head flit requests an output VC and the switch in the same cycle. If both succeed, `vc_grant` and `sw_grant` rise together, and the output port's `xb_valid`, `xb_src` (input port number) and `xb_ovc` show the transfer in that cycle.
- R4: If a head flit gets no output VC, it gets no switch grant and moves to waiting-for-VC. It keeps requesting both each cycle until an output VC becomes free.
- R5: An output VC is free when its `ovc_ready` bit (index port*VCS+vc) is 1 and no packet holds it. VC allocation gives the lowest-numbered free VC of the requested port.
- R6: An output VC stays held from its VC grant until the tail flit of that packet wins the switch. On that grant the input VC returns to idle and the output VC becomes free again. An input VC that holds a VC and has not sent its tail is active (code 3).
- R7: An active input VC makes no VC request. It requests the switch only when `ovc_credit` of its held output VC (index port*VCS+vc) is 1.
- R8: For one output port, a request from an active input VC beats any speculative head-flit request.
- R9: Per cycle, at most one input VC per input port and at most one flit per output port receive a switch grant.
- R10: Each arbiter is round-robin, and its pointer moves past the winner only when a request is granted. Two input ports contending for one output therefore alternate.
- R11: A speculative switch grant to a head flit whose VC allocation failed is discarded. No flit crosses that output in that cycle, even if the VC went to another input VC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | PORTS*VCS | Flit present at the front of each input VC |
| in_head | input | PORTS*VCS | Front flit is a head flit |
| in_tail | input | PORTS*VCS | Front flit is a tail flit (head and tail together mean a one-flit packet) |
| in_port | input | PORTS*VCS*PW | Routed output port of a head flit, PW bits per input VC |
| ovc_ready | input | PORTS*VCS | Downstream reports the output VC can take a new packet |
| ovc_credit | input | PORTS*VCS | At least one downstream buffer credit for the output VC |
| sw_grant | output | PORTS*VCS | Final switch grant per input VC; the front flit leaves |
| vc_grant | output | PORTS*VCS | Output VC granted to the input VC this cycle |
| xb_valid | output | PORTS | A flit crosses to this output port |
| xb_src | output | PORTS*PW | Input port feeding each output port |
| xb_ovc | output | PORTS*VW | Output VC used by the crossing flit |
| ivc_state | output | PORTS*VCS*2 | State of each input VC: 0 idle, 1 routing, 2 waiting-for-VC, 3 active |

## Verification
The hardest situation to reach from the ports is a discarded speculative grant. In that case the switch arbiter and the VC arbiter pick different head flits for the same output. With fresh pointers both arbiters favour the lowest index, so they always agree. The bench therefore resets first and sends one one-flit packet. This moves the VC pointer past input VC 0 and the switch pointer past input port 0. It then releases two heads from different input ports at the same time, with only one free output VC, so each arbiter picks a different head and the output stays idle. The bench also sweeps every ready pattern of one output port to check the lowest-free selection and the failed-then-retried path.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  typedef enum logic [1:0] {
    IVC_IDLE    = 2'd0,
    IVC_ROUTING = 2'd1,
    IVC_WAIT_VC = 2'd2,
    IVC_ACTIVE  = 2'd3
  } ivc_state_e;
endpackage

// File: rtl/alloc_rr_arb.sv
module alloc_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d, win;
  logic          found;
  int            idx;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    win   = '0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
        win      = IW'(idx);
      end
    end
    ptr_d = ptr_q;
    if (found) ptr_d = (int'(win) == N - 1) ? '0 : win + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/alloc_vc_stage.sv
module alloc_vc_stage #(
  parameter int P = 2,
  parameter int V = 2,
  localparam int N  = P * V,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int VW = (V > 1) ? $clog2(V) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           req,
  input  logic [N-1:0][PW-1:0]   route,
  input  logic [N-1:0]           ovc_free,
  output logic [N-1:0]           gnt,
  output logic [N-1:0][VW-1:0]   gnt_vc,
  output logic [N-1:0]           take
);
  logic [N-1:0]  gnt_po [P];
  logic [VW-1:0] low_vc [P];

  for (genvar o = 0; o < P; o++) begin : g_out
    logic [N-1:0]  rq;
    logic [VW-1:0] lv;
    logic          any_free;

    always_comb begin
      lv       = '0;
      any_free = 1'b0;
      for (int v = V - 1; v >= 0; v--) begin
        if (ovc_free[o*V + v]) begin
          lv       = VW'(v);
          any_free = 1'b1;
        end
      end
      for (int i = 0; i < N; i++)
        rq[i] = req[i] && (route[i] == PW'(o)) && any_free;
    end

    assign low_vc[o] = lv;

    alloc_rr_arb #(.N(N)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (rq),
      .adv  (|rq),
      .gnt  (gnt_po[o])
    );
  end

  always_comb begin
    gnt    = '0;
    gnt_vc = '0;
    take   = '0;
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < N; i++) begin
        if (gnt_po[o][i]) begin
          gnt[i]    = 1'b1;
          gnt_vc[i] = low_vc[o];
        end
      end
      if (|gnt_po[o]) take[o*V + int'(low_vc[o])] = 1'b1;
    end
  end
endmodule

// File: rtl/alloc_sw_stage.sv
module alloc_sw_stage #(
  parameter int P = 2,
  parameter int V = 2,
  localparam int N  = P * V,
  localparam int PW = (P > 1) ? $clog2(P) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         ns_req,
  input  logic [N-1:0]         sp_req,
  input  logic [N-1:0][PW-1:0] route,
  output logic [N-1:0]         gnt
);
  logic [V-1:0]  s1_gnt   [P];
  logic [PW-1:0] s1_route [P];
  logic [P-1:0]  s1_valid, s1_ns, in_win;
  logic [P-1:0]  s2_gnt   [P];

  // input-side stage: one candidate per input port, held-VC flits first
  for (genvar p = 0; p < P; p++) begin : g_in
    logic [V-1:0]  rns, rsp, sel, g1;
    logic [PW-1:0] rt;

    assign rns = ns_req[p*V +: V];
    assign rsp = sp_req[p*V +: V];
    assign sel = (|rns) ? rns : rsp;

    alloc_rr_arb #(.N(V)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (sel),
      .adv  (in_win[p]),
      .gnt  (g1)
    );

    always_comb begin
      rt = '0;
      for (int v = 0; v < V; v++)
        if (g1[v]) rt = route[p*V + v];
    end

    assign s1_gnt[p]   = g1;
    assign s1_route[p] = rt;
    assign s1_valid[p] = |sel;
    assign s1_ns[p]    = |rns;
  end

  // output-side stage: one input port per output, held-VC flits first
  for (genvar o = 0; o < P; o++) begin : g_out
    logic [P-1:0] cand, cand_ns, sel2;

    always_comb begin
      for (int p = 0; p < P; p++) begin
        cand[p]    = s1_valid[p] && (s1_route[p] == PW'(o));
        cand_ns[p] = cand[p] && s1_ns[p];
      end
      sel2 = (|cand_ns) ? cand_ns : cand;
    end

    alloc_rr_arb #(.N(P)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (sel2),
      .adv  (|sel2),
      .gnt  (s2_gnt[o])
    );
  end

  always_comb begin
    in_win = '0;
    for (int o = 0; o < P; o++) in_win = in_win | s2_gnt[o];
    for (int p = 0; p < P; p++)
      for (int v = 0; v < V; v++)
        gnt[p*V + v] = s1_gnt[p][v] && in_win[p];
  end
endmodule

// File: rtl/spec_vc_sw_alloc.sv
module spec_vc_sw_alloc
  import alloc_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_VCS   = 2,
  localparam int N  = NUM_PORTS * NUM_VCS,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int VW = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           in_valid,
  input  logic [N-1:0]           in_head,
  input  logic [N-1:0]           in_tail,
  input  logic [N*PW-1:0]        in_port,
  input  logic [N-1:0]           ovc_ready,
  input  logic [N-1:0]           ovc_credit,
  output logic [N-1:0]           sw_grant,
  output logic [N-1:0]           vc_grant,
  output logic [NUM_PORTS-1:0]   xb_valid,
  output logic [NUM_PORTS*PW-1:0] xb_src,
  output logic [NUM_PORTS*VW-1:0] xb_ovc,
  output logic [N*2-1:0]         ivc_state
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ivc_state_e          st_q [N];
  ivc_state_e          st_d [N];
  logic [N-1:0][PW-1:0] route_q, route_d;
  logic [N-1:0][VW-1:0] hold_q, va_vc, cur_vc;
  logic [N-1:0]        route_en;
  logic [N-1:0]        busy_q, busy_d, rel, take, ovc_free;
  logic [N-1:0]        va_req, va_gnt, ns_req, sp_req, sa_gnt;

  assign ovc_free = ovc_ready & ~busy_q;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic va_phase;
      va_phase  = (st_q[i] == IVC_ROUTING) || (st_q[i] == IVC_WAIT_VC);
      va_req[i] = in_valid[i] && va_phase;
      sp_req[i] = va_req[i] && (|ovc_free[int'(route_q[i])*NUM_VCS +: NUM_VCS]);
      ns_req[i] = in_valid[i] && (st_q[i] == IVC_ACTIVE) &&
                  ovc_credit[int'(route_q[i])*NUM_VCS + int'(hold_q[i])];
    end
  end

  alloc_vc_stage #(.P(NUM_PORTS), .V(NUM_VCS)) u_va (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (va_req),
    .route   (route_q),
    .ovc_free(ovc_free),
    .gnt     (va_gnt),
    .gnt_vc  (va_vc),
    .take    (take)
  );

  alloc_sw_stage #(.P(NUM_PORTS), .V(NUM_VCS)) u_sa (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ns_req(ns_req),
    .sp_req(sp_req),
    .route (route_q),
    .gnt   (sa_gnt)
  );

  // speculative grants survive only with a VC granted alongside
  always_comb begin
    rel = '0;
    for (int i = 0; i < N; i++) begin
      sw_grant[i] = sa_gnt[i] && ((st_q[i] == IVC_ACTIVE) || va_gnt[i]);
      cur_vc[i]   = va_gnt[i] ? va_vc[i] : hold_q[i];
      if (sw_grant[i] && in_tail[i])
        rel[int'(route_q[i])*NUM_VCS + int'(cur_vc[i])] = 1'b1;
    end
    busy_d = (busy_q | take) & ~rel;
  end

  assign vc_grant = va_gnt;

  always_comb begin
    xb_valid = '0;
    xb_src   = '0;
    xb_ovc   = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      for (int i = 0; i < N; i++) begin
        if (sw_grant[i] && (route_q[i] == PW'(o))) begin
          xb_valid[o]         = 1'b1;
          xb_src[o*PW +: PW]  = PW'(i / NUM_VCS);
          xb_ovc[o*VW +: VW]  = cur_vc[i];
        end
      end
    end
  end

  // per input VC next state
  always_comb begin
    for (int i = 0; i < N; i++) begin
      st_d[i]     = st_q[i];
      route_d[i]  = in_port[i*PW +: PW];
      route_en[i] = 1'b0;
      case (st_q[i])
        IVC_IDLE: begin
          if (in_valid[i] && in_head[i]) begin
            st_d[i]     = IVC_ROUTING;
            route_en[i] = 1'b1;
          end
        end
        IVC_ROUTING, IVC_WAIT_VC: begin
          if (va_gnt[i])
            st_d[i] = (sw_grant[i] && in_tail[i]) ? IVC_IDLE : IVC_ACTIVE;
          else if (in_valid[i])
            st_d[i] = IVC_WAIT_VC;
        end
        IVC_ACTIVE: begin
          if (sw_grant[i] && in_tail[i]) st_d[i] = IVC_IDLE;
        end
        default: st_d[i] = IVC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < N; i++) st_q[i] <= IVC_IDLE;
      busy_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) st_q[i] <= st_d[i];
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      route_q <= '0;
      hold_q  <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (route_en[i]) route_q[i] <= route_d[i];
        if (va_gnt[i])   hold_q[i]  <= va_vc[i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_st
    assign ivc_state[i*2 +: 2] = st_q[i];
  end
endmodule

// File: rtl/alloc_chk.sv
module alloc_chk
  import alloc_pkg::*;
#(
  parameter int P = 2,
  parameter int V = 2,
  localparam int N = P * V
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] in_valid,
  input logic [N-1:0] in_tail,
  input logic [N-1:0] sw_grant,
  input logic [N-1:0] vc_grant,
  input logic [N*2-1:0] ivc_state
);
  for (genvar p = 0; p < P; p++) begin : g_port
    p_one_per_inport_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sw_grant[p*V +: V]) <= 1);
  end

  for (genvar i = 0; i < N; i++) begin : g_ivc
    logic [1:0] s;
    assign s = ivc_state[i*2 +: 2];

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s == IVC_IDLE) |-> (!sw_grant[i] && !vc_grant[i]));

    p_spec_needs_vc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (((s == IVC_ROUTING) || (s == IVC_WAIT_VC)) && sw_grant[i]) |-> vc_grant[i]);

    p_fail_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (((s == IVC_ROUTING) || (s == IVC_WAIT_VC)) && in_valid[i] && !vc_grant[i])
        |=> (s == IVC_WAIT_VC));

    p_tail_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_grant[i] && in_tail[i]) |=> (s == IVC_IDLE));

    p_active_no_va_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s == IVC_ACTIVE) |-> !vc_grant[i]);
  end
endmodule

bind spec_vc_sw_alloc alloc_chk #(.P(NUM_PORTS), .V(NUM_VCS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .in_valid (in_valid),
  .in_tail  (in_tail),
  .sw_grant (sw_grant),
  .vc_grant (vc_grant),
  .ivc_state(ivc_state)
);

// File: tb/sim_spec_vc_sw_alloc.sv
`timescale 1ns/1ps
module sim_spec_vc_sw_alloc;
  localparam int P = 2, V = 2, N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] in_valid, in_head, in_tail, in_port, ovc_ready, ovc_credit;
  logic [N-1:0] sw_grant, vc_grant;
  logic [P-1:0] xb_valid, xb_src, xb_ovc;
  logic [2*N-1:0] ivc_state;

  int ntot = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spec_vc_sw_alloc #(.NUM_PORTS(P), .NUM_VCS(V)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head),
    .in_tail(in_tail), .in_port(in_port), .ovc_ready(ovc_ready),
    .ovc_credit(ovc_credit), .sw_grant(sw_grant), .vc_grant(vc_grant),
    .xb_valid(xb_valid), .xb_src(xb_src), .xb_ovc(xb_ovc),
    .ivc_state(ivc_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    ntot++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int st(input int i);
    return int'(ivc_state[i*2 +: 2]);
  endfunction

  task automatic put(input int i, input bit h, input bit t, input bit port);
    in_valid[i] = 1'b1; in_head[i] = h; in_tail[i] = t; in_port[i] = port;
  endtask

  task automatic drop(input int i);
    in_valid[i] = 1'b0; in_head[i] = 1'b0; in_tail[i] = 1'b0;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    in_valid = '0; in_head = '0; in_tail = '0; in_port = '0;
    ovc_ready = '1; ovc_credit = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    do_reset();
    #2;
    chk("R1 state", int'(ivc_state), 0);
    chk("R1 sw_grant", int'(sw_grant), 0);
    chk("R1 vc_grant", int'(vc_grant), 0);
    chk("R1 xb_valid", int'(xb_valid), 0);

    // sweep every ready pattern of output port 1 (bits 3:2)
    for (int pat = 0; pat < 4; pat++) begin
      ovc_ready = {pat[1:0], 2'b11};
      put(0, 1, 1, 1);
      #2;
      chk("R2 idle no grant", int'(sw_grant | vc_grant), 0);
      chk("R2 idle state", st(0), 0);
      step(); #2;
      chk("R2 routing state", st(0), 1);
      if (pat != 0) begin
        chk("R3 vc_grant", int'(vc_grant[0]), 1);
        chk("R3 sw_grant", int'(sw_grant[0]), 1);
        chk("R3 xb_valid", int'(xb_valid[1]), 1);
        chk("R3 xb_src", int'(xb_src[1]), 0);
        chk("R5 lowest free", int'(xb_ovc[1]), pat[0] ? 0 : 1);
      end else begin
        chk("R4 no vc", int'(vc_grant[0]), 0);
        chk("R4 no sw", int'(sw_grant[0]), 0);
        step(); #2;
        chk("R4 wait state", st(0), 2);
        ovc_ready[2] = 1'b1;
        #1;
        chk("R4 retry vc", int'(vc_grant[0]), 1);
        chk("R4 retry sw", int'(sw_grant[0]), 1);
        chk("R4 retry ovc", int'(xb_ovc[1]), 0);
      end
      step(); drop(0); #2;
      chk("R6 back idle", st(0), 0);
    end

    // multi-flit packet, credits, priority, round robin, release
    do_reset();
    put(0, 1, 0, 1);
    step(); #2;
    chk("R3 head vc", int'(vc_grant[0]), 1);
    chk("R3 head sw", int'(sw_grant[0]), 1);
    chk("R5 head ovc", int'(xb_ovc[1]), 0);
    step();
    put(0, 0, 0, 1); ovc_credit[2] = 1'b0; put(2, 1, 1, 1);
    #2;
    chk("R6 active", st(0), 3);
    chk("R7 no credit", int'(sw_grant[0]), 0);
    chk("R7 no va body", int'(vc_grant[0]), 0);
    step(); ovc_credit[2] = 1'b1; #2;
    chk("R2 second routing", st(2), 1);
    chk("R8 held wins", int'(sw_grant[0]), 1);
    chk("R8 spec loses", int'(sw_grant[2]), 0);
    chk("R8 va still ok", int'(vc_grant[2]), 1);
    chk("R9 one per out", $countones(sw_grant), 1);
    step(); put(0, 0, 1, 1); #2;
    chk("R6 va won sa lost", st(2), 3);
    chk("R10 rr other port", int'(sw_grant[2]), 1);
    chk("R10 rr loser", int'(sw_grant[0]), 0);
    chk("R10 xb_src", int'(xb_src[1]), 1);
    chk("R5 skip held", int'(xb_ovc[1]), 1);
    step(); drop(2); #2;
    chk("R6 single idle", st(2), 0);
    chk("R10 tail next", int'(sw_grant[0]), 1);
    chk("R6 tail ovc", int'(xb_ovc[1]), 0);
    step(); drop(0); put(1, 1, 1, 1); #2;
    chk("R6 tail idle", st(0), 0);
    step(); #2;
    chk("R6 vc reused", int'(vc_grant[1]), 1);
    chk("R6 reused ovc", int'(xb_ovc[1]), 0);
    step(); drop(1);

    // discarded speculation: arbiters disagree after one warm-up packet
    do_reset();
    put(0, 1, 1, 1);
    step(); #2;
    chk("R3 warm-up", int'(sw_grant[0]), 1);
    step(); drop(0);
    ovc_ready[3:2] = 2'b10;
    put(1, 1, 1, 1); put(2, 1, 1, 1);
    step(); #2;
    chk("R11 vc to ivc1", int'(vc_grant), 2);
    chk("R11 discarded", int'(sw_grant), 0);
    chk("R11 output idle", int'(xb_valid[1]), 0);
    step(); #2;
    chk("R11 winner active", st(1), 3);
    chk("R4 loser waits", st(2), 2);
    chk("R11 held sends", int'(sw_grant[1]), 1);
    chk("R4 no free no sw", int'(sw_grant[2]), 0);
    chk("R11 ovc", int'(xb_ovc[1]), 1);
    step(); drop(1); #2;
    chk("R6 freed idle", st(1), 0);
    chk("R4 retry gets vc", int'(vc_grant[2]), 1);
    chk("R4 retry sw", int'(sw_grant[2]), 1);
    chk("R4 retry ovc", int'(xb_ovc[1]), 1);
    step(); drop(2);

    // two VCs of one input port to different outputs
    do_reset();
    put(0, 1, 1, 0); put(1, 1, 1, 1);
    step(); #2;
    chk("R9 both vc", int'(vc_grant[1:0]), 3);
    chk("R9 one per inport", $countones(sw_grant[1:0]), 1);
    chk("R10 first lowest", int'(sw_grant[0]), 1);
    step(); drop(0); #2;
    chk("R9 loser active", st(1), 3);
    chk("R9 loser sends", int'(sw_grant[1]), 1);
    chk("R9 xb out1", int'(xb_valid[1]), 1);
    step(); drop(1);

    done = 1'b1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule